// File: doc/BRIEF.md
# Dual-Channel PCM Receive Deserializer

This block turns a framed serial PCM stream into two parallel 8-bit words, one per channel, each announced by a single-cycle strobe. It is clocked directly by the bit clock and takes every input bit on that clock's falling edge. A receive sync signal, phase-locked to the bit clock, marks the start of each frame. The most significant bit of a frame is the one present at the falling edge where the sync is first seen high.

In parallel mode each channel has its own data line and delivers one word per frame. In serial mode both channels share the second data line. The first eight bits after sync go to channel 1 and the next eight go to channel 2, and the first line is ignored. Frames may carry any number of bits beyond the used slots. This lets the frame rate vary (roughly 6 to 9 kHz against a fixed bit clock), and the surplus bits are discarded.

Top module: `pcm_rx_deser`

## Requirements
- R1: Data bits are sampled on the falling edge of `clk`, most significant bit first. The bit taken at the falling edge where `rsync` is first seen high (low at the previous falling edge) is the MSB of the first slot.
- R2: With `rst` high at a falling edge, both words clear to 0 and both strobes go low. After reset, no strobe is raised until a sync rising edge has been seen.
- R3: Parallel mode (`ser_mode` = 0): channel 1 is built from `din_a` and channel 2 from `din_b`. Both strobes rise together, right after the falling edge that takes the eighth bit of the frame.
- R4: Serial mode (`ser_mode` = 1): bits 1 to 8 of `din_b` after sync form the channel 1 word and bits 9 to 16 form the channel 2 word. The channel 1 strobe follows the 8th bit and the channel 2 strobe follows the 16th. `din_a` has no effect.
- R5: Each strobe is high for exactly one cycle per completed word. The word output changes only together with its strobe and holds its value until the next completion.
- R6: Bits after the last used slot of a frame are ignored until the next sync rising edge. Frames of any length that covers the used slots are accepted.
- R7: A sync rising edge that arrives before a slot is complete discards that partial word. Its strobe is not raised and the previous word stays on the output.
- R8: The mode is captured at each sync rising edge and governs the whole frame. A change of `ser_mode` in mid-frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data taken on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 0 = one line per channel, 1 = both channels on `din_b` |
| rsync | input | 1 | Receive frame sync; rising edge marks the MSB |
| din_a | input | 1 | Channel 1 data line in parallel mode |
| din_b | input | 1 | Channel 2 data line, or the multiplexed line in serial mode |
| ch1_word | output | 8 | Last completed channel 1 word |
| ch1_valid | output | 1 | One-cycle strobe on a new channel 1 word |
| ch2_word | output | 8 | Last completed channel 2 word |
| ch2_valid | output | 1 | One-cycle strobe on a new channel 2 word |

## Verification
A vector table of frames runs both modes with asymmetric word patterns (A5/3C, all-ones against all-zeros, single set bits at either end). These patterns expose bit reversal, swapped channels and off-by-one slot boundaries. The frames come in lengths of 17, 24, 30 and 40 bits, with random filler after the slots and random data on the unused line in serial mode. This shows that surplus and ignored bits leave the words alone, and the cycle at which each strobe appears separates the 8th-bit and 16th-bit completion points. Some frames flip `ser_mode` in mid-frame to show that the mode is held from sync. Directed frames cover reset, data with no sync present, and frames cut short at 5 and 12 bits, where partial words must vanish without a strobe.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } rx_mode_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic rise_o
);
  logic sync_q;

  // reset to 1 so a sync already high at reset release is not taken as an edge
  always_ff @(negedge clk) begin
    if (rst) sync_q <= 1'b1;
    else     sync_q <= sync_in;
  end

  assign rise_o = sync_in & ~sync_q;
endmodule

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos #(
  parameter int WORD_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rise_i,
  input  logic                              ser_mode_i,
  output logic [$clog2(2*WORD_W+1)-1:0]     idx_o,
  output logic [$clog2(2*WORD_W+1)-1:0]     pos_o,
  output logic                              take_o,
  output logic                              eff_ser_o,
  output logic                              frame_ser_o
);
  import pcm_rx_pkg::*;

  localparam int POS_W = $clog2(2*WORD_W+1);
  localparam logic [POS_W-1:0] ONE_SLOT = POS_W'(WORD_W);
  localparam logic [POS_W-1:0] TWO_SLOT = POS_W'(2*WORD_W);

  logic [POS_W-1:0] pos_q;
  rx_mode_e         mode_q;
  logic [POS_W-1:0] limit;

  assign eff_ser_o   = rise_i ? ser_mode_i : (mode_q == MODE_SER);
  assign limit       = eff_ser_o ? TWO_SLOT : ONE_SLOT;
  assign idx_o       = rise_i ? '0 : pos_q;
  assign take_o      = idx_o < limit;
  assign pos_o       = pos_q;
  assign frame_ser_o = (mode_q == MODE_SER);

  // position saturates at the slot limit: surplus bits are not counted
  always_ff @(negedge clk) begin
    if (rst) begin
      pos_q  <= TWO_SLOT;
      mode_q <= MODE_PAR;
    end else if (rise_i) begin
      pos_q  <= POS_W'(1);
      mode_q <= rx_mode_e'(ser_mode_i);
    end else if (take_o) begin
      pos_q  <= pos_q + POS_W'(1);
    end
  end

  // R6: the position never runs past the two-slot limit
  always_comb begin
    if (!rst) a_r6_pos_bounded: assert (pos_q <= TWO_SLOT);
  end

  // R1: a sync edge restarts the frame with the MSB consumed
  a_r1_sync_restart: assert property (@(negedge clk) disable iff (rst)
    rise_i |=> (pos_q == POS_W'(1)));

  // R8: mode stays put between sync edges
  a_r8_mode_held: assert property (@(negedge clk) disable iff (rst)
    !rise_i |=> $stable(mode_q));
endmodule

// File: rtl/pcm_slot_shift.sv
module pcm_slot_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic              last_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_next;

  assign sh_next = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(negedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (take_i) begin
        sh_q <= sh_next;
        if (last_i) begin
          word_o  <= sh_next;
          valid_o <= 1'b1;
        end
      end
    end
  end

  // R5: strobe lasts one cycle
  a_r5_single_pulse: assert property (@(negedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R5: word moves only with its strobe
  a_r5_word_hold: assert property (@(negedge clk) disable iff (rst)
    !valid_o |-> $stable(word_o));
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic              rsync,
  input  logic              din_a,
  input  logic              din_b,
  output logic [WORD_W-1:0] ch1_word,
  output logic              ch1_valid,
  output logic [WORD_W-1:0] ch2_word,
  output logic              ch2_valid
);
  import pcm_rx_pkg::*;

  localparam int POS_W = $clog2(2*WORD_W+1);
  localparam logic [POS_W-1:0] ONE_SLOT = POS_W'(WORD_W);
  localparam logic [POS_W-1:0] TWO_SLOT = POS_W'(2*WORD_W);

  logic             rise;
  logic [POS_W-1:0] idx;
  logic [POS_W-1:0] pos;
  logic             take_any;
  logic             eff_ser;
  logic             frame_ser;

  logic [NUM_CH-1:0]       ch_take;
  logic [NUM_CH-1:0]       ch_last;
  logic [NUM_CH-1:0]       ch_bit;
  logic [NUM_CH-1:0]       ch_valid;
  logic [WORD_W-1:0]       ch_word [NUM_CH];

  pcm_sync_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .sync_in (rsync),
    .rise_o  (rise)
  );

  pcm_frame_pos #(.WORD_W(WORD_W)) u_pos (
    .clk         (clk),
    .rst         (rst),
    .rise_i      (rise),
    .ser_mode_i  (ser_mode),
    .idx_o       (idx),
    .pos_o       (pos),
    .take_o      (take_any),
    .eff_ser_o   (eff_ser),
    .frame_ser_o (frame_ser)
  );

  // channel 0 reads line a in parallel mode, line b otherwise; channel 1 always line b
  assign ch_bit[0] = eff_ser ? din_b : din_a;
  assign ch_bit[1] = din_b;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [POS_W-1:0] lo;
    assign lo = (g != 0 && eff_ser) ? ONE_SLOT : '0;
    assign ch_take[g] = take_any && (idx >= lo) && (idx < lo + ONE_SLOT);
    assign ch_last[g] = (idx == lo + ONE_SLOT - POS_W'(1));

    pcm_slot_shift #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .take_i  (ch_take[g]),
      .last_i  (ch_last[g]),
      .bit_i   (ch_bit[g]),
      .word_o  (ch_word[g]),
      .valid_o (ch_valid[g])
    );
  end

  assign ch1_word  = ch_word[0];
  assign ch2_word  = ch_word[1];
  assign ch1_valid = ch_valid[0];
  assign ch2_valid = ch_valid[1];

  // R3/R4: channel 1 completes exactly when the frame has consumed one slot
  a_r3_ch1_at_slot_end: assert property (@(negedge clk) disable iff (rst)
    ch1_valid |-> (pos == ONE_SLOT));

  // R4: channel 2 completes after two slots in serial mode, one in parallel
  a_r4_ch2_at_slot_end: assert property (@(negedge clk) disable iff (rst)
    ch2_valid |-> (pos == (frame_ser ? TWO_SLOT : ONE_SLOT)));

  // R3: in parallel frames the two strobes coincide
  a_r3_par_together: assert property (@(negedge clk) disable iff (rst)
    (ch1_valid && !frame_ser) |-> ch2_valid);
endmodule

// File: tb/tb_pcm_rx_deser.sv
module tb_pcm_rx_deser;
  logic clk = 1'b0;
  logic rst, ser_mode, rsync, din_a, din_b;
  logic [7:0] ch1_word, ch2_word;
  logic ch1_valid, ch2_valid;

  int errors = 0;
  int checks = 0;
  logic [7:0] prev1 = 8'h00;
  logic [7:0] prev2 = 8'h00;

  always #10 clk = ~clk;

  pcm_rx_deser #(.WORD_W(8)) dut (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .rsync(rsync),
    .din_a(din_a), .din_b(din_b),
    .ch1_word(ch1_word), .ch1_valid(ch1_valid),
    .ch2_word(ch2_word), .ch2_valid(ch2_valid)
  );

  // {mode, flip, len, word1, word2}
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 1'b0, 8'd24, 8'hA5, 8'h3C},
    {1'b0, 1'b0, 8'd17, 8'hFF, 8'h00},
    {1'b0, 1'b0, 8'd40, 8'h01, 8'h80},
    {1'b0, 1'b1, 8'd24, 8'h7E, 8'h81},
    {1'b1, 1'b0, 8'd24, 8'hC3, 8'h5A},
    {1'b1, 1'b0, 8'd17, 8'h00, 8'hFF},
    {1'b1, 1'b0, 8'd40, 8'h80, 8'h01},
    {1'b1, 1'b1, 8'd30, 8'h96, 8'h69}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit mode, input bit flip, input int len,
                           input logic [7:0] a, input logic [7:0] b,
                           input string req);
    int n1 = 0, n2 = 0, c1 = -1, c2 = -1;
    logic [7:0] w1 = 8'h00, w2 = 8'h00;
    bit e1, e2;
    int ec2;
    for (int c = 0; c < len; c++) begin
      @(posedge clk); #1;
      if (ch1_valid) begin n1++; c1 = c; w1 = ch1_word; end
      if (ch2_valid) begin n2++; c2 = c; w2 = ch2_word; end
      rsync    = (c < 2);
      ser_mode = (flip && c >= 3) ? ~mode : mode;
      din_a    = 1'($urandom);
      din_b    = 1'($urandom);
      if (c < 8) begin
        if (mode) din_b = a[7-c];
        else begin din_a = a[7-c]; din_b = b[7-c]; end
      end else if (c < 16 && mode) begin
        din_b = b[15-c];
      end
    end
    @(posedge clk); #1;
    e1  = (len >= 9);
    e2  = mode ? (len >= 17) : (len >= 9);
    ec2 = mode ? 16 : 8;
    check(n1 == (e1 ? 1 : 0), req, "ch1 strobe count", n1, e1 ? 1 : 0);
    check(n2 == (e2 ? 1 : 0), req, "ch2 strobe count", n2, e2 ? 1 : 0);
    if (e1) begin
      check(c1 == 8, req, "ch1 strobe cycle", c1, 8);
      check(w1 == a, req, "ch1 word at strobe", w1, a);
      prev1 = a;
    end
    if (e2) begin
      check(c2 == ec2, req, "ch2 strobe cycle", c2, ec2);
      check(w2 == b, req, "ch2 word at strobe", w2, b);
      prev2 = b;
    end
    check(ch1_word == prev1, req, "ch1 word held", ch1_word, prev1);
    check(ch2_word == prev2, req, "ch2 word held", ch2_word, prev2);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; ser_mode = 1'b0; rsync = 1'b0; din_a = 1'b0; din_b = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    check(ch1_word == 8'h00 && ch2_word == 8'h00, "R2", "words after reset",
          {ch1_word, ch2_word}, 0);
    check(!ch1_valid && !ch2_valid, "R2", "strobes after reset",
          {ch1_valid, ch2_valid}, 0);
    rst = 1'b0;
    // R2: no strobe before the first sync edge
    n = 0;
    for (int c = 0; c < 24; c++) begin
      @(posedge clk); #1;
      if (ch1_valid || ch2_valid) n++;
      din_a = 1'($urandom);
      din_b = 1'($urandom);
    end
    check(n == 0, "R2", "strobes without sync", n, 0);

    // R1 R3 R4 R5 R6 R8: table of frames in both modes
    for (int i = 0; i < 8; i++) begin
      run_frame(VEC[i][25], VEC[i][24], int'(VEC[i][23:16]),
                VEC[i][15:8], VEC[i][7:0],
                VEC[i][25] ? (VEC[i][24] ? "R8" : "R4") : (VEC[i][24] ? "R8" : "R3"));
    end

    // R7: parallel frame cut at 5 bits, then serial frame cut at 12
    run_frame(1'b0, 1'b0, 5, 8'h12, 8'h34, "R7");
    run_frame(1'b1, 1'b0, 12, 8'h5C, 8'hE1, "R7");
    // R1: recovery after truncated frames
    run_frame(1'b0, 1'b0, 20, 8'hB4, 8'h2D, "R1");
    run_frame(1'b1, 1'b0, 18, 8'h0F, 8'hF0, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule